// File: doc/BRIEF.md
# Flash Safety Timeout Controller

This block gates a single flash current sink and keeps it from staying on too long. A stored configuration word holds a 3-bit current code, a mode bit that marks the code as a flash or a spotlight setting, and a guard bit that turns the safety timeout on. The sink is driven only while an external enable pin is high, the stored code is nonzero and no timeout is latched. The pin is brought into the clock domain through a small synchronizer.

While the sink is driven and the guard is set, a counter counts pulses of a one-millisecond tick. When 1000 ticks have been counted without a break, the block latches a timed-out state and forces the sink off. The sink stays off until one of two re-arm events happens. The first is the synchronized pin going low. The second is a nonzero code being written while the stored code is zero, so software has to clear the code and then write it again.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_guard`

## Requirements
- R1: After reset the stored code is 0, the mode bit is 0, the guard bit is 1, `drive_en` is 0 and `timed_out` is 0.
- R2: `flash_pin` passes through a 2-stage synchronizer. `drive_en` is 1 exactly when the synchronized pin is 1, the stored code is nonzero and `timed_out` is 0.
- R3: `drive_code` equals the stored code while `drive_en` is 1 and is 0 otherwise. `drive_flash_mode` always shows the stored mode bit (1 = flash, 0 = spotlight).
- R4: A cycle with `cfg_wr` high loads the code, the mode bit and the guard bit together. The new values are visible from the next cycle.
- R5: With the guard set, the tick that is the 1000th one counted during continuous driving sets `timed_out` on the following cycle, and `drive_en` is 0 from that cycle on.
- R6: The tick count restarts from zero in every cycle in which the sink is not driven or the guard is clear.
- R7: With the guard clear, `timed_out` never rises, however many ticks arrive.
- R8: A synchronized pin value of 0 clears `timed_out` on the next cycle.
- R9: A write of a nonzero code while the stored code is 0 clears `timed_out`. A nonzero write while the stored code is nonzero leaves it set.
- R10: When a write and an expiring tick fall in the same cycle, expiry is judged on the values held before the write. The timeout latches even if that write clears the code or the guard bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| flash_pin | input | 1 | External flash enable pin, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_code | input | 3 | Current code to store |
| cfg_flash_mode | input | 1 | Mode to store: 1 = flash, 0 = spotlight |
| cfg_guard_en | input | 1 | Safety timeout enable to store |
| drive_en | output | 1 | Enable for the current sink |
| drive_code | output | 3 | Current code applied to the sink |
| drive_flash_mode | output | 1 | Mode of the applied code |
| timed_out | output | 1 | Latched timeout status |

## Verification
Two functions can land on the same clock edge: the expiring tick, and a configuration write that clears the code or the guard bit. The bench lines the two up by counting 999 ticks and then presenting the 1000th tick together with a write of code 0. Per R10, `timed_out` must rise and the code must read 0, and a later nonzero write must then re-arm the sink. Random stimulus also drops the pin and issues writes near expiry, and a cycle-level bench model judges every output on each cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              flash;
    logic              guard;
  } flash_cfg_t;

  localparam flash_cfg_t CFG_RESET = '{code: '0, flash: 1'b0, guard: 1'b1};
endpackage

// File: rtl/flash_guard_sync.sv
module flash_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/flash_guard_cfg.sv
module flash_guard_cfg
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_flash,
  input  logic              wr_guard,
  output flash_cfg_t        cfg,
  output logic              code_rearm
);
  flash_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr) begin
      cfg_q.code  <= wr_code;
      cfg_q.flash <= wr_flash;
      cfg_q.guard <= wr_guard;
    end
  end

  // nonzero write on top of a cleared code re-arms the timeout latch
  assign code_rearm = wr && (wr_code != '0) && (cfg_q.code == '0);
  assign cfg = cfg_q;

  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg_q.code == $past(wr_code)) && (cfg_q.guard == $past(wr_guard)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q));
endmodule

// File: rtl/flash_guard_timer.sv
module flash_guard_timer #(
  parameter int TICK_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic driving,
  input  logic guard,
  input  logic pin_high,
  input  logic code_rearm,
  output logic expired
);
  localparam int CW = (TICK_LIMIT > 1) ? $clog2(TICK_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          expired_q;
  logic          fire;

  assign fire = tick && driving && guard && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!driving || !guard) cnt <= '0;
    else if (tick)             cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          expired_q <= 1'b0;
    else if (!pin_high)  expired_q <= 1'b0;
    else if (fire)       expired_q <= 1'b1;
    else if (code_rearm) expired_q <= 1'b0;
  end

  assign expired = expired_q;

  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!driving || !guard) |=> (cnt == '0));
  a_r7_no_fire_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    !guard |=> !$rose(expired_q));
  a_r8_pin_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_high |=> !expired_q);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && pin_high && !code_rearm) |=> expired_q);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int TICK_LIMIT  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              flash_pin,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_flash_mode,
  input  logic              cfg_guard_en,
  output logic              drive_en,
  output logic [CODE_W-1:0] drive_code,
  output logic              drive_flash_mode,
  output logic              timed_out
);
  flash_cfg_t cfg;
  logic       pin_s;
  logic       code_rearm;
  logic       expired;
  logic       driving;

  flash_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(flash_pin), .q_sync(pin_s));

  flash_guard_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_code(cfg_code),
    .wr_flash(cfg_flash_mode), .wr_guard(cfg_guard_en),
    .cfg(cfg), .code_rearm(code_rearm));

  assign driving = pin_s && (cfg.code != '0) && !expired;

  flash_guard_timer #(.TICK_LIMIT(TICK_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .driving(driving),
    .guard(cfg.guard), .pin_high(pin_s), .code_rearm(code_rearm),
    .expired(expired));

  assign drive_en         = driving;
  assign drive_code       = driving ? cfg.code : '0;
  assign drive_flash_mode = cfg.flash;
  assign timed_out        = expired;

  a_r5_expiry_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> !drive_en);
  a_r2_no_drive_latched: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (drive_code == '0));
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int LIMIT = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, flash_pin = 1'b0, cfg_wr = 1'b0;
  logic [2:0] cfg_code = '0;
  logic cfg_flash_mode = 1'b0, cfg_guard_en = 1'b1;
  logic drive_en, drive_flash_mode, timed_out;
  logic [2:0] drive_code;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .flash_pin(flash_pin),
    .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_flash_mode(cfg_flash_mode),
    .cfg_guard_en(cfg_guard_en), .drive_en(drive_en), .drive_code(drive_code),
    .drive_flash_mode(drive_flash_mode), .timed_out(timed_out));

  // cycle-level reference model built from the requirements
  logic m_s1, m_s2, m_flash, m_guard, m_to;
  logic [2:0] m_code;
  int m_cnt;

  function automatic logic m_on(logic s2, logic [2:0] c, logic t);
    return s2 && (c != 0) && !t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_code <= 0; m_flash <= 0; m_guard <= 1;
      m_to <= 0; m_cnt <= 0;
    end else begin
      logic on;
      on = m_on(m_s2, m_code, m_to);
      m_s1 <= flash_pin; m_s2 <= m_s1;
      if (!m_s2) m_to <= 0;
      else if (tick_ms && on && m_guard && m_cnt == LIMIT-1) m_to <= 1;
      else if (cfg_wr && cfg_code != 0 && m_code == 0) m_to <= 0;
      if (!on || !m_guard) m_cnt <= 0;
      else if (tick_ms) m_cnt <= (m_cnt == LIMIT-1) ? 0 : m_cnt + 1;
      if (cfg_wr) begin
        m_code <= cfg_code; m_flash <= cfg_flash_mode; m_guard <= cfg_guard_en;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    logic e_on;
    e_on = m_on(m_s2, m_code, m_to);
    check(drive_en == e_on, "R2 drive_en", drive_en, e_on);
    check(drive_code == (e_on ? m_code : 3'd0), "R3 drive_code", drive_code, e_on ? m_code : 0);
    check(drive_flash_mode == m_flash, "R3 mode", drive_flash_mode, m_flash);
    check(timed_out == m_to, "R5 timed_out", timed_out, m_to);
  end

  task automatic cyc(input logic tk, input logic wr, input logic [2:0] c,
                     input logic fm, input logic g);
    @(negedge clk);
    tick_ms = tk; cfg_wr = wr; cfg_code = c; cfg_flash_mode = fm; cfg_guard_en = g;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(timed_out == 0 && drive_en == 0 && drive_flash_mode == 0, "R1 reset", timed_out, 0);

    // R4: write code 5, flash mode, guard on
    cyc(0, 1, 3'd5, 1, 1); flash_pin = 1; idle(3);
    check(drive_en == 1 && drive_code == 5, "R4 write visible", drive_code, 5);
    check(drive_flash_mode == 1, "R3 flash mode", drive_flash_mode, 1);

    // R5: 999 ticks no timeout, 1000th latches
    ticks(999);
    check(timed_out == 0, "R5 before limit", timed_out, 0);
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    check(timed_out == 1 && drive_en == 0, "R5 expiry", timed_out, 1);

    // R9: nonzero over nonzero keeps latch; clear then rewrite re-arms
    cyc(0, 1, 3'd6, 0, 1); idle(2);
    check(timed_out == 1, "R9 sticky", timed_out, 1);
    cyc(0, 1, 3'd0, 0, 1); cyc(0, 1, 3'd4, 0, 1); idle(2);
    check(timed_out == 0 && drive_en == 1, "R9 rearm", timed_out, 0);

    // R8: expire again, then pin low re-arms
    ticks(1000); idle(1);
    check(timed_out == 1, "R8 setup", timed_out, 1);
    flash_pin = 0; idle(3);
    check(timed_out == 0, "R8 pin rearm", timed_out, 0);
    flash_pin = 1; idle(3);
    check(drive_en == 1, "R8 drive back", drive_en, 1);

    // R6: pin drop mid-window restarts count
    ticks(600); flash_pin = 0; idle(3); flash_pin = 1; idle(3);
    ticks(999);
    check(timed_out == 0, "R6 restart", timed_out, 0);
    ticks(1);
    check(timed_out == 1, "R6 full window", timed_out, 1);
    flash_pin = 0; idle(3); flash_pin = 1; idle(3);

    // R7: guard clear, no timeout
    cyc(0, 1, 3'd7, 1, 0); idle(1);
    ticks(1500);
    check(timed_out == 0 && drive_en == 1, "R7 unguarded", timed_out, 0);

    // R10: expiring tick in same cycle as write of code 0
    cyc(0, 1, 3'd3, 0, 1); idle(1);
    ticks(999);
    cyc(1, 1, 3'd0, 0, 1); cyc(0, 0, 0, 0, 0);
    check(timed_out == 1, "R10 expiry wins", timed_out, 1);
    check(drive_code == 0, "R10 code cleared", drive_code, 0);
    cyc(0, 1, 3'd2, 0, 1); idle(2);
    check(timed_out == 0 && drive_en == 1, "R10 rearm after", timed_out, 0);

    // R10: expiry with same-cycle guard clear
    ticks(999);
    cyc(1, 1, 3'd2, 0, 0); cyc(0, 0, 0, 0, 0);
    check(timed_out == 1, "R10 guard clear same cycle", timed_out, 1);

    // random phase, judged by the model every cycle
    for (int i = 0; i < 60000; i++) begin
      logic wr;
      wr = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 999) == 0) flash_pin = ~flash_pin;
      if ($urandom_range(0, 4999) == 0) flash_pin = 1;
      cyc(logic'($urandom_range(0, 1)), wr,
          ($urandom_range(0, 3) == 0) ? 3'd0 : 3'($urandom_range(1, 7)),
          logic'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0));
    end
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule